// File: doc/BRIEF.md
# Barrel Shifter with Carry

A purely combinational operand shifter for a data-processing and load/store datapath. It takes a 32-bit operand and a 3-bit shift-kind code, and returns the shifted word together with a carry-out. The supported kinds are logical left, logical right, arithmetic right, rotate right, and a single-step rotate right through the carry flag.

The shift amount comes from one of two sources, picked by a select pin. The first is a 5-bit immediate field. The second is the low byte of a register, so register amounts run from 0 to 255. Every value in that range has a defined result and carry. The incoming carry flag is passed through whenever the shift leaves it untouched.

The block has no clock and no state. The result settles in the same cycle as the inputs, so it sits directly inside the execute stage that uses it. For that reason it has no valid/ready handshake: the surrounding pipeline stage owns flow control, and the shifter simply follows its inputs.

Top module: `shf_barrel_top`

## Requirements
- R1: The kind code selects the operation: 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate right, and 4 is rotate right by one through carry.
- R2: With `amt_sel_i` = 0 the amount is `imm_amt_i`, zero-extended to 8 bits. With `amt_sel_i` = 1 the amount is `reg_amt_i`, and the other source has no effect on the outputs.
- R3: For kinds 0 to 3 with an amount of zero, `res_o` equals the operand and `cout_o` equals `cin_i`.
- R4: Logical left by n, for 1 ≤ n ≤ 32, gives the operand shifted left by n with zeros entering at bit 0. The carry is operand bit 32−n.
- R5: Logical right by n, for 1 ≤ n ≤ 32, gives the operand shifted right by n with zeros entering at bit 31. The carry is operand bit n−1.
- R6: Logical left or logical right by any amount from 33 to 255 gives a result of zero and a carry of zero.
- R7: Arithmetic right by n fills vacated bits with operand bit 31.
  - For 1 ≤ n ≤ 31, the carry is operand bit n−1.
  - For n ≥ 32, every result bit equals operand bit 31, and so does the carry.
- R8: Rotate right by a nonzero n rotates by n mod 32, and the carry equals result bit 31. A nonzero multiple of 32 therefore returns the operand unchanged, with the carry equal to operand bit 31.
- R9: Rotate through carry gives `{cin_i, operand[31:1]}` with a carry of operand bit 0, whatever the amount.
- R10: Kind codes 5, 6 and 7 return the operand unchanged, with `cout_o` equal to `cin_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_i | input | 32 | Operand to shift |
| kind_i | input | 3 | Shift-kind code |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 8 | Low byte of the amount register |
| amt_sel_i | input | 1 | 1 = take the amount from `reg_amt_i` |
| cin_i | input | 1 | Current carry flag |
| res_o | output | 32 | Shifted result |
| cout_o | output | 1 | Shifter carry-out |

## Verification
The bench sweeps every kind code against every register amount from 0 to 255 and both carry-in values. Each sweep uses six operands:
- all zeros and all ones, which separate zero fill from sign fill;
- a value with only its end bits set, which exposes carry taken from the wrong bit position;
- two alternating patterns;
- a mixed word, which catches a rotate that wraps by the wrong count.

The amounts 32, 33, 64 and 255 fall inside the sweep and separate exact-width shifts from over-range shifts and multiple-of-32 rotates. A second sweep drives the immediate path with a conflicting register byte. It shows that the amount select really chooses the source.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    KIND_SHL  = 3'd0,
    KIND_SHR  = 3'd1,
    KIND_SRA  = 3'd2,
    KIND_ROTR = 3'd3,
    KIND_ROTC = 3'd4
  } shk_e;
endpackage

// File: rtl/shf_amount.sv
module shf_amount #(
  parameter int W         = 32,
  parameter int IMM_W     = 5,
  parameter int REG_AMT_W = 8,
  localparam int CNT_W    = $clog2(W + 1),
  localparam int ROT_W    = $clog2(W)
) (
  input  logic [IMM_W-1:0]     imm_amt_i,
  input  logic [REG_AMT_W-1:0] reg_amt_i,
  input  logic                 amt_sel_i,
  output logic [REG_AMT_W-1:0] n_o,
  output logic                 zero_o,
  output logic                 over_o,
  output logic [CNT_W-1:0]     clamp_o,
  output logic [ROT_W-1:0]     rot_o
);
  logic [REG_AMT_W-1:0] n;

  always_comb begin
    n = amt_sel_i ? reg_amt_i : REG_AMT_W'(imm_amt_i);
  end

  assign n_o     = n;
  assign zero_o  = (n == '0);
  assign over_o  = (n > REG_AMT_W'(W));
  assign clamp_o = over_o ? CNT_W'(W) : CNT_W'(n);
  assign rot_o   = n[ROT_W-1:0];
endmodule

// File: rtl/shf_funnel.sv
module shf_funnel #(
  parameter int W      = 32,
  localparam int CNT_W = $clog2(W + 1),
  localparam int DIN_W = 2 * W + 1
) (
  input  logic [DIN_W-1:0] din_i,
  input  logic [CNT_W-1:0] amt_i,
  output logic [W:0]       dout_o
);
  logic [DIN_W-1:0] stg [CNT_W+1];

  assign stg[0] = din_i;

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    assign stg[s+1] = amt_i[s] ? (stg[s] >> (1 << s)) : stg[s];
  end

  assign dout_o = stg[CNT_W][W:0];

  logic unused_hi;
  assign unused_hi = ^stg[CNT_W][DIN_W-1:W+1];
endmodule

// File: rtl/shf_barrel_top.sv
module shf_barrel_top
  import shf_pkg::*;
#(
  parameter int W         = 32,
  parameter int IMM_W     = 5,
  parameter int REG_AMT_W = 8,
  localparam int CNT_W    = $clog2(W + 1),
  localparam int ROT_W    = $clog2(W)
) (
  input  logic [W-1:0]         opd_i,
  input  logic [2:0]           kind_i,
  input  logic [IMM_W-1:0]     imm_amt_i,
  input  logic [REG_AMT_W-1:0] reg_amt_i,
  input  logic                 amt_sel_i,
  input  logic                 cin_i,
  output logic [W-1:0]         res_o,
  output logic                 cout_o
);
  logic [REG_AMT_W-1:0] n;
  logic                 amt_zero;
  logic                 amt_over;
  logic [CNT_W-1:0]     amt_clamp;
  logic [ROT_W-1:0]     amt_rot;

  shf_amount #(.W(W), .IMM_W(IMM_W), .REG_AMT_W(REG_AMT_W)) amt_i (
    .imm_amt_i (imm_amt_i),
    .reg_amt_i (reg_amt_i),
    .amt_sel_i (amt_sel_i),
    .n_o       (n),
    .zero_o    (amt_zero),
    .over_o    (amt_over),
    .clamp_o   (amt_clamp),
    .rot_o     (amt_rot)
  );

  // left shifts run through the right funnel on a bit-reversed operand
  logic [W-1:0] opd_rev;
  logic [W:0]   fun_out;
  logic [W-1:0] fun_rev;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign opd_rev[i] = opd_i[W-1-i];
    assign fun_rev[i] = fun_out[W-i];
  end

  logic [W-1:0]   fill;
  logic [W-1:0]   body;
  logic [CNT_W-1:0] famt;

  always_comb begin
    fill = '0;
    body = opd_i;
    famt = '0;
    case (kind_i)
      KIND_SHL:  begin body = opd_rev; famt = amt_clamp; end
      KIND_SHR:  famt = amt_clamp;
      KIND_SRA:  begin fill = {W{opd_i[W-1]}}; famt = amt_clamp; end
      KIND_ROTR: begin fill = opd_i; famt = CNT_W'(amt_rot); end
      KIND_ROTC: begin fill = {W{cin_i}}; famt = CNT_W'(1); end
      default:   famt = '0;
    endcase
  end

  shf_funnel #(.W(W)) fun_i (
    .din_i  ({fill, body, 1'b0}),
    .amt_i  (famt),
    .dout_o (fun_out)
  );

  logic reserved_kind;
  logic logical_kind;
  assign reserved_kind = (kind_i > 3'(KIND_ROTC));
  assign logical_kind  = (kind_i == KIND_SHL) || (kind_i == KIND_SHR);

  always_comb begin
    res_o  = (kind_i == KIND_SHL) ? fun_rev : fun_out[W:1];
    cout_o = fun_out[0];
    if (reserved_kind || ((kind_i <= 3'(KIND_ROTR)) && amt_zero)) begin
      res_o  = opd_i;
      cout_o = cin_i;
    end else if (logical_kind && amt_over) begin
      res_o  = '0;
      cout_o = 1'b0;
    end else if (kind_i == KIND_ROTR) begin
      cout_o = fun_out[W];
    end
  end

  always_comb begin
    if (!$isunknown({opd_i, kind_i, imm_amt_i, reg_amt_i, amt_sel_i, cin_i})) begin
      if (kind_i == KIND_SHL && !amt_zero && !amt_over)
        AST_SHL_LOW_CLEAR: assert ((res_o & ~({W{1'b1}} << n)) == '0); // R4
      if (kind_i == KIND_SHR && !amt_zero && !amt_over)
        AST_SHR_TOP_CLEAR: assert (res_o[W-1] == 1'b0); // R5
      if (kind_i == KIND_SRA && !amt_zero)
        AST_SRA_SIGN_KEEP: assert (res_o[W-1] == opd_i[W-1]); // R7
      if (kind_i == KIND_ROTR)
        AST_ROTR_WEIGHT: assert ($countones(res_o) == $countones(opd_i)); // R8
      if (kind_i == KIND_ROTC)
        AST_ROTC_ENDS: assert (res_o[W-1] == cin_i && cout_o == opd_i[0]); // R9
    end
  end
endmodule

// File: tb/shf_barrel_top_tb_top.sv
`timescale 1ns/1ps
module shf_barrel_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opd_i = '0;
  logic [2:0]  kind_i = '0;
  logic [4:0]  imm_amt_i = '0;
  logic [7:0]  reg_amt_i = '0;
  logic        amt_sel_i = 1'b0;
  logic        cin_i = 1'b0;
  logic [31:0] res_o;
  logic        cout_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shf_barrel_top dut_i (
    .opd_i(opd_i), .kind_i(kind_i), .imm_amt_i(imm_amt_i),
    .reg_amt_i(reg_amt_i), .amt_sel_i(amt_sel_i), .cin_i(cin_i),
    .res_o(res_o), .cout_o(cout_o)
  );

  function automatic void model(input logic [31:0] a, input logic [2:0] k,
                                input logic [7:0] n, input logic c,
                                output logic [31:0] r, output logic co);
    logic [63:0]        e;
    logic signed [63:0] se;
    int                 rr;
    r = a; co = c;
    if (k > 3'd4) return;
    if (k == 3'd4) begin r = {c, a[31:1]}; co = a[0]; return; end
    if (n == 8'd0) return;
    case (k)
      3'd0: begin e = {32'b0, a} << n; r = e[31:0]; co = e[32]; end
      3'd1: begin e = {a, 32'b0} >> n; r = e[63:32]; co = e[31]; end
      3'd2: begin se = $signed({a, 32'b0}) >>> n; r = se[63:32]; co = se[31]; end
      default: begin
        rr = int'(n) % 32;
        r = (a >> rr) | ((rr == 0) ? 32'b0 : (a << (32 - rr)));
        co = r[31];
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] k, input logic [7:0] n);
    if (k > 3'd4) return "R1/R10";
    if (k == 3'd4) return "R1/R9";
    if (n == 8'd0) return "R1/R3";
    case (k)
      3'd0: return (n > 8'd32) ? "R1/R6" : "R1/R4";
      3'd1: return (n > 8'd32) ? "R1/R6" : "R1/R5";
      3'd2: return "R1/R7";
      default: return "R1/R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input logic ec);
    n_chk++;
    if (res_o !== er || cout_o !== ec) begin
      n_bad++;
      $display("FAIL %s kind=%0d opd=%h amt_sel=%0b imm=%0d reg=%0d cin=%0b: res=%h cout=%0b expected res=%h cout=%0b",
               tag, kind_i, opd_i, amt_sel_i, imm_amt_i, reg_amt_i, cin_i,
               res_o, cout_o, er, ec);
    end
  endtask

  logic [31:0] pats [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                            32'hAAAA_5555, 32'h5555_AAAA, 32'hC3A5_0F96};

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] er;
    logic        ec;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 idle", 32'h0, 1'b0);

    // register-sourced amounts: every kind, every byte value
    for (int k = 0; k < 8; k++)
      for (int n = 0; n < 256; n++)
        for (int p = 0; p < 6; p++)
          for (int c = 0; c < 2; c++) begin
            @(posedge clk);
            kind_i    = 3'(k);
            amt_sel_i = 1'b1;
            reg_amt_i = 8'(n);
            imm_amt_i = 5'(~n);
            opd_i     = pats[p];
            cin_i     = c[0];
            @(negedge clk);
            model(pats[p], 3'(k), 8'(n), c[0], er, ec);
            check(tag_of(3'(k), 8'(n)), er, ec);
          end

    // immediate-sourced amounts with a conflicting register byte
    for (int k = 0; k < 5; k++)
      for (int n = 0; n < 32; n++)
        for (int p = 0; p < 6; p++)
          for (int c = 0; c < 2; c++) begin
            @(posedge clk);
            kind_i    = 3'(k);
            amt_sel_i = 1'b0;
            imm_amt_i = 5'(n);
            reg_amt_i = 8'(n) ^ 8'hA7;
            opd_i     = pats[p];
            cin_i     = c[0];
            @(negedge clk);
            model(pats[p], 3'(k), 8'(n), c[0], er, ec);
            check("R2 immediate source", er, ec);
          end

    finish_run();
  end
endmodule